// File: doc/BRIEF.md
# Shared Exclusive Victim Cache Controller

This block holds the tags and the replacement policy of a last-level cache that several cores share. It works as a victim store. Lines enter it only when a core's private cache evicts them. Refills from memory go past it. The data array, the memory side and all coherence traffic other than one sharer bit per core per line belong to other blocks.

Each way records a valid bit, a tag, a sharer mask with one bit per core, and an age. When a read hits a line that the reading core alone has used, the controller removes the line, because that core now holds it privately. When the line also carries the bit of another core, the controller keeps it and adds the reader to the mask. This is how a line that one core has evicted reaches a second core.

An eviction of a line that is already resident only merges the evicting core's sharer bit into it. An eviction of a new line goes to a free way. If the set has no free way, the new line replaces the oldest way. Only one operation is handled per cycle. A pending eviction takes the slot, and a read waits.

Top module: `vc_ctrl`

## Requirements
- R1: Reset clears every valid bit, and `resp_valid` stays low while reset is applied. The first read after reset therefore misses.
- R2: A read that misses allocates nothing, so repeating it misses again. An eviction-fill never produces a response.
- R3: A read hit on a line whose sharer mask has no bit other than the reader's answers hit=1, kept=0, and invalidates the line. A repeated read then misses.
- R4: A read hit on a line whose mask holds the bit of another core answers hit=1, kept=1. The line stays valid and the reader's bit is added to the mask. `resp_kept` is never high without `resp_hit`.
- R5: An eviction-fill whose tag is already resident in the set ORs the evicting core's bit into the mask of that way. No second copy is made.
- R6: An eviction-fill of a new line uses the lowest-numbered invalid way of the set if there is one, before any valid way is replaced.
- R7: In a full set, a new line replaces the way with the highest age, taking the lowest index on a tie. A way's age is cleared when it is installed or hit while kept. Every other valid way in that set ages by one and saturates at its maximum.
- R8: When `fill_valid` and `rd_valid` are both high, the fill is handled and `rd_ready` is low. The read must be held, and it is served in a later cycle, so it sees the filled line.
- R9: A read accepted on a clock edge (`rd_valid && rd_ready`) gives `resp_valid` high for exactly the following cycle, with `resp_hit`, `resp_kept` and `resp_core` set to the reading core. An address is split with its low log2(SETS) bits as the set index and the next TAG_W bits as the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A private cache evicts a line |
| fill_core | input | CORE_W | Core that evicts the line |
| fill_addr | input | ADDR_W | Line address of the evicted line |
| rd_valid | input | 1 | A core requests a line |
| rd_core | input | CORE_W | Requesting core |
| rd_addr | input | ADDR_W | Line address requested |
| rd_ready | output | 1 | Read accepted this cycle (low while a fill is pending) |
| resp_valid | output | 1 | Lookup result is valid |
| resp_hit | output | 1 | Requested line was resident |
| resp_kept | output | 1 | Line stays resident after the hit |
| resp_core | output | CORE_W | Core the response belongs to |

## Verification
An eviction-fill and a read can arrive in the same cycle. The bench provokes this by raising both on one edge for the same line, with the read coming from a different core. It then checks that `rd_ready` is low in that cycle and high in the next while the read is held. The read must answer hit with kept set, which can only happen if the fill was installed first. The scoreboard also flags any response that arrives while no read is outstanding.

// File: rtl/vc_pkg.sv
package vc_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_FILL = 2'd1,
        OP_READ = 2'd2
    } vc_op_e;

endpackage

// File: rtl/vc_tag_match.sv
module vc_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           idx_o
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

    always_comb begin
        idx_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) idx_o = WAY_W'(w);
        end
    end

    assign hit_o = |match;

endmodule

// File: rtl/vc_victim_sel.sv
module vc_victim_sel #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 3,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][AGE_W-1:0] ages_i,
    output logic [WAY_W-1:0]           idx_o
);

    logic             free_found;
    logic [WAY_W-1:0] free_idx;
    logic [WAY_W-1:0] old_idx;
    logic [AGE_W-1:0] old_age;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!free_found && !valid_i[w]) begin
                free_found = 1'b1;
                free_idx   = WAY_W'(w);
            end
        end
    end

    always_comb begin
        old_idx = '0;
        old_age = ages_i[0];
        for (int w = 1; w < WAYS; w++) begin
            if (ages_i[w] > old_age) begin
                old_age = ages_i[w];
                old_idx = WAY_W'(w);
            end
        end
    end

    assign idx_o = free_found ? free_idx : old_idx;

endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
    import vc_pkg::*;
#(
    parameter int CORES  = 4,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 6,
    parameter int AGE_W  = 3,
    parameter int CORE_W = $clog2(CORES),
    parameter int ADDR_W = TAG_W + $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [CORE_W-1:0] fill_core,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              rd_valid,
    input  logic [CORE_W-1:0] rd_core,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_kept,
    output logic [CORE_W-1:0] resp_core
);

    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [CORES-1:0]  sharers;
        logic [AGE_W-1:0]  age;
    } way_t;

    typedef way_t [WAYS-1:0] set_t;

    typedef struct packed {
        set_t [SETS-1:0]   sets;
        logic              resp_valid;
        logic              resp_hit;
        logic              resp_kept;
        logic [CORE_W-1:0] resp_core;
    } state_t;

    state_t st_d, st_q;

    vc_op_e            op;
    logic [CORE_W-1:0] op_core;
    logic [ADDR_W-1:0] op_addr;
    logic [SET_W-1:0]  op_set;
    logic [TAG_W-1:0]  op_tag;
    logic [CORES-1:0]  core_bit;

    set_t                       cur;
    set_t                       nxt;
    logic [WAYS-1:0]            cur_valid;
    logic [WAYS-1:0][TAG_W-1:0] cur_tags;
    logic [WAYS-1:0][AGE_W-1:0] cur_ages;
    logic                       hit;
    logic [WAY_W-1:0]           hit_idx;
    logic [WAY_W-1:0]           vic_idx;
    logic [WAY_W-1:0]           tgt_idx;
    logic                       do_age;
    logic [CORES-1:0]           others;

    // arbitration: an eviction always wins the single slot
    always_comb begin
        if (fill_valid) begin
            op      = OP_FILL;
            op_core = fill_core;
            op_addr = fill_addr;
        end else if (rd_valid) begin
            op      = OP_READ;
            op_core = rd_core;
            op_addr = rd_addr;
        end else begin
            op      = OP_NONE;
            op_core = rd_core;
            op_addr = rd_addr;
        end
    end

    assign rd_ready = !fill_valid;
    assign op_set   = op_addr[SET_W-1:0];
    assign op_tag   = op_addr[ADDR_W-1:SET_W];
    assign core_bit = CORES'(1) << op_core;
    assign cur      = st_q.sets[op_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_unpack
        assign cur_valid[w] = cur[w].valid;
        assign cur_tags[w]  = cur[w].tag;
        assign cur_ages[w]  = cur[w].age;
    end

    vc_tag_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W)
    ) u_match (
        .valid_i (cur_valid),
        .tags_i  (cur_tags),
        .tag_i   (op_tag),
        .hit_o   (hit),
        .idx_o   (hit_idx)
    );

    vc_victim_sel #(
        .WAYS  (WAYS),
        .AGE_W (AGE_W),
        .WAY_W (WAY_W)
    ) u_victim (
        .valid_i (cur_valid),
        .ages_i  (cur_ages),
        .idx_o   (vic_idx)
    );

    always_comb begin
        st_d            = st_q;
        st_d.resp_valid = 1'b0;
        st_d.resp_hit   = 1'b0;
        st_d.resp_kept  = 1'b0;
        nxt             = cur;
        tgt_idx         = hit_idx;
        do_age          = 1'b0;
        others          = cur[hit_idx].sharers & ~core_bit;

        case (op)
            OP_FILL: begin
                do_age = 1'b1;
                if (hit) begin
                    nxt[hit_idx].sharers = cur[hit_idx].sharers | core_bit;
                    tgt_idx              = hit_idx;
                end else begin
                    nxt[vic_idx].valid   = 1'b1;
                    nxt[vic_idx].tag     = op_tag;
                    nxt[vic_idx].sharers = core_bit;
                    tgt_idx              = vic_idx;
                end
            end
            OP_READ: begin
                st_d.resp_valid = 1'b1;
                st_d.resp_core  = op_core;
                st_d.resp_hit   = hit;
                if (hit) begin
                    if (|others) begin
                        st_d.resp_kept       = 1'b1;
                        nxt[hit_idx].sharers = cur[hit_idx].sharers | core_bit;
                        do_age               = 1'b1;
                    end else begin
                        nxt[hit_idx].valid   = 1'b0;
                        nxt[hit_idx].sharers = '0;
                    end
                end
            end
            default: ;
        endcase

        if (do_age) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == tgt_idx) begin
                    nxt[w].age = '0;
                end else if (nxt[w].valid && nxt[w].age != AGE_MAX) begin
                    nxt[w].age = nxt[w].age + 1'b1;
                end
            end
        end

        st_d.sets[op_set] = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.resp_valid;
    assign resp_hit   = st_q.resp_hit;
    assign resp_kept  = st_q.resp_kept;
    assign resp_core  = st_q.resp_core;

endmodule

// File: rtl/vc_ctrl_chk.sv
module vc_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic fill_valid,
    input logic rd_valid,
    input logic rd_ready,
    input logic resp_valid,
    input logic resp_hit,
    input logic resp_kept
);

    AST_FILL_STALLS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !rd_ready); // R8

    AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(rd_valid && rd_ready)); // R9

    AST_KEEP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_kept |-> (resp_valid && resp_hit)); // R4

    AST_FILL_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !resp_valid); // R2

endmodule

bind vc_ctrl vc_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (fill_valid),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_kept  (resp_kept)
);

// File: tb/vc_ctrl_tb.sv
module vc_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CORE_W = 2;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fill_valid = 1'b0;
    logic [CORE_W-1:0] fill_core = '0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic              rd_valid = 1'b0;
    logic [CORE_W-1:0] rd_core = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_ready;
    logic              resp_valid;
    logic              resp_hit;
    logic              resp_kept;
    logic [CORE_W-1:0] resp_core;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [3:0] exp_q[$];   // {hit, kept, core}
    string      req_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    vc_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_core  (fill_core),
        .fill_addr  (fill_addr),
        .rd_valid   (rd_valid),
        .rd_core    (rd_core),
        .rd_addr    (rd_addr),
        .rd_ready   (rd_ready),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_kept  (resp_kept),
        .resp_core  (resp_core)
    );

    function automatic logic [ADDR_W-1:0] la(int tag, int set);
        return {6'(tag), 2'(set)};
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: compare every response with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", 1, 0);
            end else begin
                automatic logic [3:0] e = exp_q.pop_front();
                automatic string      r = req_q.pop_front();
                check({resp_hit, resp_kept, resp_core} == e, r,
                      int'({resp_hit, resp_kept, resp_core}), int'(e));
            end
        end
    end

    // drivers, called at a falling edge
    task automatic fill(int c, logic [ADDR_W-1:0] a);
        fill_valid = 1'b1;
        fill_core  = CORE_W'(c);
        fill_addr  = a;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic rd(int c, logic [ADDR_W-1:0] a, bit hit, bit kept, string req);
        rd_valid = 1'b1;
        rd_core  = CORE_W'(c);
        rd_addr  = a;
        exp_q.push_back({hit, kept, 2'(c)});
        req_q.push_back(req);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(resp_valid == 1'b0, "R1 resp_valid in reset", int'(resp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty after reset
        rd(0, la(5, 0), 1'b0, 1'b0, "R1 first read misses");

        // R2: a miss allocates nothing
        rd(1, la(9, 3), 1'b0, 1'b0, "R2 miss one");
        rd(1, la(9, 3), 1'b0, 1'b0, "R2 miss repeated");

        // R3: sole sharer reads its own line
        fill(0, la(1, 0));
        rd(0, la(1, 0), 1'b1, 1'b0, "R3 sole-sharer hit drops line");
        rd(0, la(1, 0), 1'b0, 1'b0, "R3 line gone after hit");

        // R4: line evicted by core 1 read by core 2
        fill(1, la(2, 0));
        rd(2, la(2, 0), 1'b1, 1'b1, "R4 shared hit kept");
        rd(2, la(2, 0), 1'b1, 1'b1, "R4 still resident");
        rd(1, la(2, 0), 1'b1, 1'b1, "R4 reader bit added");

        // R5: second eviction of the same line merges the sharer bit
        fill(0, la(3, 3));
        fill(1, la(3, 3));
        rd(0, la(3, 3), 1'b1, 1'b1, "R5 merged sharers keep line");

        // R7: full set, oldest way replaced
        for (int t = 10; t < 14; t++) fill(0, la(t, 1));
        rd(3, la(10, 1), 1'b1, 1'b1, "R7 refresh way 0");
        fill(0, la(14, 1));
        rd(3, la(11, 1), 1'b0, 1'b0, "R7 oldest evicted");
        rd(3, la(12, 1), 1'b1, 1'b1, "R7 younger kept a");
        rd(3, la(13, 1), 1'b1, 1'b1, "R7 younger kept b");
        rd(3, la(14, 1), 1'b1, 1'b1, "R7 new line present");
        rd(3, la(10, 1), 1'b1, 1'b1, "R7 refreshed line kept");

        // R6: a freed way is reused before the oldest is replaced
        for (int t = 20; t < 24; t++) fill(0, la(t, 2));
        rd(0, la(21, 2), 1'b1, 1'b0, "R6 free a way");
        fill(0, la(25, 2));
        rd(1, la(20, 2), 1'b1, 1'b1, "R6 oldest not evicted");
        rd(1, la(25, 2), 1'b1, 1'b1, "R6 new line present");
        rd(1, la(21, 2), 1'b0, 1'b0, "R6 freed line stays gone");
        rd(1, la(22, 2), 1'b1, 1'b1, "R6 other line kept");

        // R8: fill and read of the same line in one cycle
        fill_valid = 1'b1;
        fill_core  = 2'd2;
        fill_addr  = la(30, 3);
        rd_valid   = 1'b1;
        rd_core    = 2'd3;
        rd_addr    = la(30, 3);
        exp_q.push_back({1'b1, 1'b1, 2'd3});
        req_q.push_back("R8 read served after fill");
        #1;
        check(rd_ready == 1'b0, "R8 read stalled by fill", int'(rd_ready), 0);
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        check(rd_ready == 1'b1, "R8 read accepted next", int'(rd_ready), 1);
        @(negedge clk);
        rd_valid = 1'b0;

        // R9: response lasts exactly one cycle
        @(negedge clk);
        check(resp_valid == 1'b0, "R9 single-cycle response", int'(resp_valid), 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all responses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule